// File: doc/BRIEF.md
# Invalidation Descriptor Queue Engine

This block drains a ring of 128-bit invalidation commands that software places in memory. Software fills entries and then moves a tail register forward. The engine reads one entry at a time at the head position over a simple read port and looks at the 4-bit type code. It does one of three things with the entry. Cache-invalidation commands (context cache, IOTLB, device IOTLB and interrupt-entry cache) go to a downstream port under a valid/ready handshake. Wait commands finish with a 32-bit status write to memory, a one-cycle completion pulse, or both. Entries it cannot read or cannot decode raise a fault.

While the fault is raised, the head stays on the bad entry, so software can inspect the entry, repair it and clear the fault. Fetching then resumes at that same slot. A wait command with its fence bit set is held back until every command already dispatched has been acknowledged downstream.

Top module: `inv_queue_engine`

## Requirements
- R1: After reset the head index is 0, the fault flag and the completion pulse are low, and no read, write or dispatch request is active.
- R2: A fetch starts only while the enable input is high, no fault is pending and the head index differs from the tail index. Its address is the page base (page number input followed by 12 zero bits) plus 16 times the head index.
- R3: An entry whose low-word bits 3:0 are 1, 2, 3 or 4 is presented as the whole 128-bit entry on the dispatch port, with the low word in bits 63:0. It stays stable until ready is seen, and the head then advances by one.
- R4: The queue size code (3 bits, clamped to the maximum parameter) gives 2^(code+8) entries. The head wraps to 0 after the last entry. The head output carries the index in bits 18:4, and the tail input is read from bits 18:4.
- R5: For a wait entry (type 5) with status-write bit 5 set, the engine writes low-word bits 63:32 to the high-word address with bits 1:0 cleared. It holds the request stable until acknowledged, and the head advances on the acknowledge.
- R6: For a wait entry with interrupt-flag bit 4 set, the engine raises a one-cycle completion pulse when the entry completes.
- R7: For a wait entry with fence bit 6 set, no status write, pulse or head advance occurs while any dispatched command lacks its done acknowledge.
- R8: A type code of 0 or 6 to 15 sets the fault flag, leaves the head on that entry and dispatches nothing.
- R9: A read returned with the error input set sets the fault flag and leaves the head on that entry.
- R10: While the fault flag is set no fetch is made. Pulsing the fault-clear input clears the flag, and the same entry is fetched again.
- R11: Only one read is outstanding, and the read request and address stay stable until read data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Queue enable |
| qs_i | input | 3 | Queue size code |
| base_pfn_i | input | ADDR_W-12 | Page number of the ring base |
| tail_reg_i | input | 32 | Tail register, index in bits 18:4 |
| fault_clr_i | input | 1 | Clears the fault flag |
| rd_req_o | output | 1 | Entry read request |
| rd_addr_o | output | ADDR_W | Entry read address |
| rd_valid_i | input | 1 | Read data returned |
| rd_err_i | input | 1 | Read failed |
| rd_data_i | input | 128 | Entry data, low word in bits 63:0 |
| inv_valid_o | output | 1 | Dispatch valid |
| inv_ready_i | input | 1 | Dispatch accepted |
| inv_desc_o | output | 128 | Dispatched entry |
| inv_done_i | input | 1 | One dispatched command has completed |
| wr_req_o | output | 1 | Status write request |
| wr_addr_o | output | ADDR_W | Status write address |
| wr_data_o | output | 32 | Status write data |
| wr_ack_i | input | 1 | Status write accepted |
| irq_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Fault flag |
| head_reg_o | output | 32 | Head register, index in bits 18:4 |

## Verification
The assertions check on every cycle that the read, dispatch and status-write requests hold steady until accepted. They also check that the completion pulse lasts one cycle, that the head cannot move while the fault flag is set, and that no fetch follows a cycle with the fault raised. Other behaviours only show up in the bench's scenarios, because they depend on memory contents and the order of events. These are the decoding of each type code, the status value and address, the fence wait on outstanding acknowledges, the wrap from the last slot to slot 0, the refetch of a repaired entry after the fault is cleared, and the behaviour while the queue is disabled.

// File: rtl/inv_q_pkg.sv
`timescale 1ns/1ps
package inv_q_pkg;
  localparam int unsigned DESC_W = 128;

  localparam logic [3:0] TY_CTX    = 4'd1;
  localparam logic [3:0] TY_IOTLB  = 4'd2;
  localparam logic [3:0] TY_DEVTLB = 4'd3;
  localparam logic [3:0] TY_IEC    = 4'd4;
  localparam logic [3:0] TY_WAIT   = 4'd5;

  typedef enum logic [1:0] {K_INV, K_WAIT, K_BAD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_STATUS} state_e;

  typedef struct packed {
    logic [63:0] hi;
    logic [63:0] lo;
  } desc_t;
endpackage

// File: rtl/inv_q_decode.sv
`timescale 1ns/1ps
module inv_q_decode
  import inv_q_pkg::*;
(
  input  logic [6:0] lo_i,
  output kind_e      kind_o,
  output logic       fence_o,
  output logic       sw_o,
  output logic       irq_flag_o
);
  always_comb begin
    case (lo_i[3:0])
      TY_CTX, TY_IOTLB, TY_DEVTLB, TY_IEC: kind_o = K_INV;
      TY_WAIT:                            kind_o = K_WAIT;
      default:                            kind_o = K_BAD;
    endcase
  end

  assign fence_o    = lo_i[6];
  assign sw_o       = lo_i[5];
  assign irq_flag_o = lo_i[4];
endmodule

// File: rtl/inv_q_ptr.sv
`timescale 1ns/1ps
module inv_q_ptr #(
  parameter int unsigned MAX_QS = 7,
  parameter int unsigned IDX_W  = MAX_QS + 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       qs_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] head_o,
  output logic             empty_o
);
  localparam int unsigned SPAN_W = IDX_W + 1;

  logic [2:0]        qs_eff;
  logic [SPAN_W-1:0] span;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  head_q;

  assign qs_eff   = (qs_i > 3'(MAX_QS)) ? 3'(MAX_QS) : qs_i;
  assign span     = SPAN_W'(1) << ({1'b0, qs_eff} + 4'd8);
  assign last_idx = IDX_W'(span - SPAN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    head_q <= '0;
    else if (adv_i) head_q <= (head_q == last_idx) ? '0 : head_q + 1'b1;
  end

  assign head_o  = head_q;
  assign empty_o = (head_q == (tail_i & last_idx));
endmodule

// File: rtl/inv_q_track.sv
`timescale 1ns/1ps
module inv_q_track #(
  parameter int unsigned CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec_ok;

  assign dec_ok = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign zero_o = (cnt_q == '0);
  assign full_o = &cnt_q;
endmodule

// File: rtl/inv_queue_engine.sv
`timescale 1ns/1ps
module inv_queue_engine
  import inv_q_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned MAX_QS = 7,
  parameter int unsigned OUT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        qs_i,
  input  logic [ADDR_W-13:0] base_pfn_i,
  input  logic [31:0]       tail_reg_i,
  input  logic              fault_clr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic              rd_err_i,
  input  logic [127:0]      rd_data_i,
  output logic              inv_valid_o,
  input  logic              inv_ready_i,
  output logic [127:0]      inv_desc_o,
  input  logic              inv_done_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  input  logic              wr_ack_i,
  output logic              irq_o,
  output logic              fault_o,
  output logic [31:0]       head_reg_o
);
  localparam int unsigned IDX_W = MAX_QS + 8;
  localparam int unsigned REG_W = 32;

  state_e st_q, st_d;
  desc_t  desc_q, rd_desc;
  logic   fault_q, irq_q;

  logic [IDX_W-1:0] head, tail_idx;
  logic             empty, trk_zero, trk_full;
  logic             issue_fire, wait_go, complete, adv, bad_fetch;

  kind_e rd_kind, unused_kind;
  logic  unused_rd_fence, unused_rd_sw, unused_rd_if;
  logic  w_fence, w_sw, w_if;
  logic  unused_tail_bits;

  assign rd_desc          = desc_t'(rd_data_i);
  assign tail_idx         = tail_reg_i[4 +: IDX_W];
  assign unused_tail_bits = ^{tail_reg_i[3:0], tail_reg_i[REG_W-1:IDX_W+4]};

  inv_q_decode u_dec_rd (
    .lo_i       (rd_desc.lo[6:0]),
    .kind_o     (rd_kind),
    .fence_o    (unused_rd_fence),
    .sw_o       (unused_rd_sw),
    .irq_flag_o (unused_rd_if)
  );

  inv_q_decode u_dec_hold (
    .lo_i       (desc_q.lo[6:0]),
    .kind_o     (unused_kind),
    .fence_o    (w_fence),
    .sw_o       (w_sw),
    .irq_flag_o (w_if)
  );

  inv_q_ptr #(.MAX_QS(MAX_QS), .IDX_W(IDX_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .qs_i    (qs_i),
    .tail_i  (tail_idx),
    .adv_i   (adv),
    .head_o  (head),
    .empty_o (empty)
  );

  inv_q_track #(.CNT_W(OUT_W)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (issue_fire),
    .dec_i  (inv_done_i),
    .zero_o (trk_zero),
    .full_o (trk_full)
  );

  assign issue_fire = inv_valid_o && inv_ready_i;
  assign wait_go    = (st_q == S_WAIT) && (!w_fence || trk_zero);
  assign complete   = (wait_go && !w_sw) || ((st_q == S_STATUS) && wr_ack_i);
  assign adv        = issue_fire || complete;
  assign bad_fetch  = (st_q == S_FETCH) && rd_valid_i && (rd_err_i || rd_kind == K_BAD);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (en_i && !fault_q && !empty) st_d = S_FETCH;
      S_FETCH:  if (rd_valid_i) begin
                  if (rd_err_i || rd_kind == K_BAD) st_d = S_IDLE;
                  else if (rd_kind == K_INV)        st_d = S_ISSUE;
                  else                              st_d = S_WAIT;
                end
      S_ISSUE:  if (issue_fire) st_d = S_IDLE;
      S_WAIT:   if (wait_go) st_d = w_sw ? S_STATUS : S_IDLE;
      S_STATUS: if (wr_ack_i) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      desc_q  <= '0;
      fault_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= complete && w_if;
      if (st_q == S_FETCH && rd_valid_i) desc_q <= rd_desc;
      if (bad_fetch)        fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign rd_req_o    = (st_q == S_FETCH);
  assign rd_addr_o   = {base_pfn_i, 12'h000} + (ADDR_W'(head) << 4);
  assign inv_valid_o = (st_q == S_ISSUE) && !trk_full;
  assign inv_desc_o  = desc_q;
  assign wr_req_o    = (st_q == S_STATUS);
  assign wr_addr_o   = {desc_q.hi[ADDR_W-1:2], 2'b00};
  assign wr_data_o   = desc_q.lo[63:32];
  assign irq_o       = irq_q;
  assign fault_o     = fault_q;
  assign head_reg_o  = REG_W'(head) << 4;
endmodule

// File: rtl/inv_queue_engine_chk.sv
`timescale 1ns/1ps
module inv_queue_engine_chk #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              inv_valid_o,
  input logic              inv_ready_i,
  input logic [127:0]      inv_desc_o,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [31:0]       wr_data_o,
  input logic              wr_ack_i,
  input logic              irq_o,
  input logic              fault_o,
  input logic [31:0]       head_reg_o
);
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  assert_inv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !inv_ready_i |=> inv_valid_o && $stable(inv_desc_o));

  assert_wr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_head_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(head_reg_o));

  assert_no_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !rd_req_o);
endmodule

bind inv_queue_engine inv_queue_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .inv_valid_o (inv_valid_o),
  .inv_ready_i (inv_ready_i),
  .inv_desc_o  (inv_desc_o),
  .wr_req_o    (wr_req_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_ack_i    (wr_ack_i),
  .irq_o       (irq_o),
  .fault_o     (fault_o),
  .head_reg_o  (head_reg_o)
);

// File: tb/inv_queue_engine_bench.sv
`timescale 1ns/1ps
module inv_queue_engine_bench;
  localparam int AW = 48;
  localparam logic [AW-13:0] PFN  = 36'h0_0008_0001;
  localparam logic [AW-1:0]  BASE = {PFN, 12'h000};

  // {hi, lo}
  localparam logic [127:0] VEC [8] = '{
    {64'h0, 64'h0000_0012_0034_0011},
    {64'h0000_0000_0abc_d000, 64'h0000_0000_0056_00d2},
    {64'h0000_0000_0001_f000, 64'h0001_2300_0000_0003},
    {64'h0, 64'h0000_0040_0800_0014},
    {64'h0000_0000_0020_0007, 64'hcafe_0001_0000_0025},
    {64'h0, 64'h0000_0000_0000_0015},
    {64'h0000_0000_0020_0010, 64'h1234_5678_0000_0075},
    {64'h0, 64'h0000_0000_0000_0032}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, fault_clr = 1'b0;
  logic [31:0] tail_reg = '0;
  logic rd_req, rd_valid, rd_err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [127:0] rd_data, inv_desc;
  logic inv_valid, inv_ready, inv_done, wr_req, wr_ack, irq, fault;
  logic [31:0] wr_data, head_reg;
  logic done_q, done_man = 1'b0, auto_done = 1'b1;

  logic [127:0] mem [256];
  int err_idx = -1;
  int checks = 0, errs = 0, nxt = 0;
  int fetch_cnt = 0, inv_cnt = 0, wr_cnt = 0, irq_cnt = 0;
  logic [127:0] last_inv;
  logic [AW-1:0] last_addr, last_wr_addr;
  logic [31:0] last_wr_data;
  logic rd_req_d, rd_busy, saw_wrap = 1'b0;
  int rd_cnt;

  always #10 clk = ~clk;

  assign inv_done = done_q | done_man;

  inv_queue_engine #(.ADDR_W(AW)) u_inv_queue_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .qs_i(3'd0), .base_pfn_i(PFN),
    .tail_reg_i(tail_reg), .fault_clr_i(fault_clr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid),
    .rd_err_i(rd_err), .rd_data_i(rd_data),
    .inv_valid_o(inv_valid), .inv_ready_i(inv_ready), .inv_desc_o(inv_desc),
    .inv_done_i(inv_done),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
    .irq_o(irq), .fault_o(fault), .head_reg_o(head_reg)
  );

  // memory read responder, three cycles of latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_err <= 1'b0; rd_data <= '0; rd_busy <= 1'b0; rd_cnt <= 0;
    end else begin
      rd_valid <= 1'b0;
      if (rd_req && !rd_valid && !rd_busy) begin
        rd_busy <= 1'b1; rd_cnt <= 1;
      end else if (rd_busy) begin
        if (rd_cnt == 0) begin
          rd_valid <= 1'b1;
          rd_data  <= mem[int'((rd_addr - BASE) >> 4) & 255];
          rd_err   <= ((int'((rd_addr - BASE) >> 4) & 255) == err_idx);
          rd_busy  <= 1'b0;
        end else rd_cnt <= rd_cnt - 1;
      end
    end
  end

  // dispatch sink, status-write sink and monitors
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_ready <= 1'b0; wr_ack <= 1'b0; done_q <= 1'b0; rd_req_d <= 1'b0;
      last_addr <= '0;
    end else begin
      inv_ready <= inv_valid && !inv_ready;
      wr_ack    <= wr_req && !wr_ack;
      done_q    <= auto_done && inv_valid && inv_ready;
      rd_req_d  <= rd_req;
      if (inv_valid && inv_ready) begin inv_cnt <= inv_cnt + 1; last_inv <= inv_desc; end
      if (wr_req && wr_ack) begin
        wr_cnt <= wr_cnt + 1; last_wr_addr <= wr_addr; last_wr_data <= wr_data;
      end
      if (irq) irq_cnt <= irq_cnt + 1;
      if (rd_req && !rd_req_d) begin
        fetch_cnt <= fetch_cnt + 1;
        last_addr <= rd_addr;
        if (rd_addr == BASE && last_addr == BASE + 48'hff0) saw_wrap <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_head(input int idx);
    int n = 0;
    while (head_reg != (32'(idx) << 4) && n < 6000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic push(input logic [127:0] d);
    mem[nxt] = d;
    nxt = (nxt + 1) % 256;
    tail_reg = 32'(nxt) << 4;
  endtask

  initial begin
    repeat (1500) @(posedge clk);
    repeat (148500) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int ic, wc, qc, fc, h0;
    logic [3:0] ty;
    for (int j = 0; j < 256; j++) mem[j] = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk(head_reg == 0 && !fault && !irq, "R1 head/fault/irq", {head_reg, fault, irq}, 0);
    chk(!rd_req && !inv_valid && !wr_req, "R1 no requests", {rd_req, inv_valid, wr_req}, 0);
    cycles(5);
    chk(fetch_cnt == 0, "R2 empty queue not fetched", fetch_cnt, 0);

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      ic = inv_cnt; wc = wr_cnt; qc = irq_cnt;
      push(VEC[i]);
      wait_head(nxt);
      cycles(3);
      chk(last_addr == BASE + 48'(i) * 48'd16, "R2 fetch address", last_addr, BASE + 48'(i) * 48'd16);
      ty = VEC[i][3:0];
      if (ty >= 4'd1 && ty <= 4'd4) begin
        chk(inv_cnt == ic + 1, "R3 dispatch count", inv_cnt, ic + 1);
        chk(last_inv == VEC[i], "R3 dispatched entry", last_inv, VEC[i]);
      end else begin
        chk(wr_cnt == wc + int'(VEC[i][5]), "R5 status write count", wr_cnt, wc + int'(VEC[i][5]));
        if (VEC[i][5]) begin
          chk(last_wr_data == VEC[i][63:32], "R5 status data", last_wr_data, VEC[i][63:32]);
          chk(last_wr_addr == {VEC[i][64+AW-1:66], 2'b00}, "R5 status address",
              last_wr_addr, {VEC[i][64+AW-1:66], 2'b00});
        end
        chk(irq_cnt == qc + int'(VEC[i][4]), "R6 completion pulse", irq_cnt, qc + int'(VEC[i][4]));
      end
    end

    // R2 disabled queue
    en = 1'b0; fc = fetch_cnt; ic = inv_cnt;
    push({64'h0, 64'h0000_0000_0000_0011});
    cycles(20);
    chk(fetch_cnt == fc && head_reg == 32'h80, "R2 no fetch while disabled", {fetch_cnt, head_reg}, {fc, 32'h80});
    en = 1'b1;
    wait_head(9); cycles(3);
    chk(inv_cnt == ic + 1, "R2 fetch after enable", inv_cnt, ic + 1);

    // R7 fence waits for the done acknowledge
    auto_done = 1'b0; wc = wr_cnt;
    push({64'h0, 64'h0000_0000_0001_0002});
    push({64'h0000_0000_0030_0000, 64'hfeed_0007_0000_0065});
    cycles(30);
    chk(head_reg == 32'(10) << 4 && wr_cnt == wc, "R7 fence holds wait entry", {head_reg, wr_cnt}, {32'(10) << 4, wc});
    done_man = 1'b1; cycles(1); done_man = 1'b0;
    wait_head(11); cycles(3);
    chk(wr_cnt == wc + 1 && last_wr_data == 32'hfeed_0007, "R7 wait completes after done",
        last_wr_data, 32'hfeed_0007);
    auto_done = 1'b1;

    // R8 invalid type 7, then R10 repair and clear
    ic = inv_cnt;
    push({64'h0, 64'h0000_0000_0000_0007});
    cycles(20);
    chk(fault == 1'b1, "R8 fault on type 7", fault, 1);
    chk(head_reg == 32'(11) << 4 && inv_cnt == ic, "R8 head held, nothing dispatched", head_reg, 32'(11) << 4);
    fc = fetch_cnt;
    mem[11] = {64'h0, 64'h0000_0000_0000_0021};
    cycles(10);
    chk(fetch_cnt == fc, "R10 no fetch while faulted", fetch_cnt, fc);
    fault_clr = 1'b1; cycles(1); fault_clr = 1'b0;
    wait_head(12); cycles(3);
    chk(!fault && inv_cnt == ic + 1, "R10 refetch after clear", {fault, inv_cnt}, {1'b0, ic + 1});
    chk(last_inv == {64'h0, 64'h0000_0000_0000_0021}, "R10 repaired entry dispatched", last_inv,
        {64'h0, 64'h0000_0000_0000_0021});

    // R8 type 0
    push({64'h0, 64'h0});
    cycles(20);
    chk(fault && head_reg == 32'(12) << 4, "R8 fault on type 0", {fault, head_reg}, {1'b1, 32'(12) << 4});
    mem[12] = {64'h0, 64'h0000_0000_0000_0014};
    fault_clr = 1'b1; cycles(1); fault_clr = 1'b0;
    wait_head(13); cycles(2);

    // R9 read error
    ic = inv_cnt; err_idx = 13;
    push({64'h0, 64'h0000_0000_0000_0003});
    cycles(20);
    chk(fault && head_reg == 32'(13) << 4 && inv_cnt == ic, "R9 read error faults", {fault, head_reg}, {1'b1, 32'(13) << 4});
    err_idx = -1;
    fault_clr = 1'b1; cycles(1); fault_clr = 1'b0;
    wait_head(14); cycles(3);
    chk(!fault && inv_cnt == ic + 1, "R9 recovery", inv_cnt, ic + 1);

    // R4 wrap from entry 255 to 0
    for (int j = 0; j < 256; j++) mem[j] = {64'h0, 64'h0000_0000_0000_0014};
    ic = inv_cnt; h0 = 14;
    tail_reg = 32'(255) << 4;
    wait_head(255);
    tail_reg = 32'(2) << 4;
    wait_head(2); cycles(3);
    chk(head_reg == 32'h20, "R4 head index after wrap", head_reg, 32'h20);
    chk(saw_wrap, "R4 entry 0 fetched after entry 255", saw_wrap, 1);
    chk(inv_cnt == ic + (255 - h0) + 3, "R4 entries consumed across wrap", inv_cnt, ic + (255 - h0) + 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule